// File: doc/BRIEF.md
# Serial Character Transmitter with Graceful Disable

This block turns parallel characters into an asynchronous serial stream. A character buffer offers a character with a valid/ready handshake; once accepted, the character is framed as one low start bit, 5 to 8 data bits sent least significant bit first, and one high stop bit. Every bit lasts 16 pulses of an oversample tick that the surrounding logic supplies, so the bit rate is set by the tick rate and not by the core clock.

Two enables gate the transmitter: a global enable for the whole serial port and a transmit-section enable. New characters are accepted only while both are set. Clearing either one while a character is on the line never truncates it: the frame runs to the end of its stop bit, and only then does the transmitter stop taking new work. The word-length code is captured together with each character, so it may change between characters without corrupting a frame. At reset the code reads as 8 data bits, giving a default of 8 data bits, no parity and one stop bit.

Top module: `uart_tx_graceful`

## Requirements
- R1: After reset and whenever no character is being sent, `serialOut` is high and `busy` is low, including while either enable is clear.
- R2: An accepted character produces one low start bit, then its data bits least significant bit first, then one high stop bit.
- R3: The word-length code captured with the character selects the number of data bits: code 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7, 2'b11 gives 8.
- R4: Data bits above the selected word length have no effect on the line; the stop bit directly follows the last selected data bit.
- R5: `dataReady` is high only when the transmitter is idle and both `globalEn` and `txEn` are high; a cycle with `dataValid` and `dataReady` both high accepts the character and the start bit appears on `serialOut` after that clock edge.
- R6: While `globalEn` or `txEn` is low, no character is accepted and the line stays high, even with `dataValid` held high.
- R7: Clearing `globalEn` or `txEn` during a frame lets that frame complete with all its bits and its stop bit; afterwards no further character is accepted until both enables are set again.
- R8: `busy` is high from the clock edge that starts the start bit until the end of the stop bit, and low afterwards.
- R9: Each bit lasts exactly 16 `ovsTick` pulses; the line changes only on a clock edge with `ovsTick` high, except for the start bit which begins at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ovsTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| globalEn | input | 1 | Serial port global enable |
| txEn | input | 1 | Transmit-section enable |
| wordLenCode | input | 2 | Data bits per character: 00=5, 01=6, 10=7, 11=8 |
| dataIn | input | 8 | Character from the buffer |
| dataValid | input | 1 | Buffer offers a character |
| dataReady | output | 1 | Transmitter takes the offered character this cycle |
| serialOut | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is on the line |

## Verification
A wrong bit counter or a stale word-length capture shows as a stop bit arriving one or more bit times early or late, so the line is sampled at the middle of every bit and any misplaced edge is caught within one bit time (16 ticks). A tick counter that ignores `ovsTick` stretches or shrinks every bit and is exposed with a slowed tick, where mid-bit samples drift into the wrong bit within the first two bits. A state machine that obeys the enables mid-frame instead of finishing shows as `busy` falling and the line returning high before the expected stop bit, visible at the first mid-bit sample after the enable drops.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } utxState_e;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic load;   // capture character, drive start bit
    logic shift;  // drive next data bit
    logic stop;   // drive stop bit
  } utxStrobe_t;

endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int OVS_RATIO = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ovsTick,
  input  logic       globalEn,
  input  logic       txEn,
  input  logic [1:0] wordLenCode,
  input  logic       dataValid,
  output logic       dataReady,
  output logic       busy,
  output utxStrobe_t strobe
);

  localparam int TW = (OVS_RATIO > 1) ? $clog2(OVS_RATIO) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(OVS_RATIO - 1);

  utxState_e  state;
  logic [TW-1:0] tickCnt;
  logic [2:0] bitCnt;
  logic [1:0] codeQ;
  logic [2:0] bitLast;
  logic       tickEnd;
  logic       accept;
  logic       lastBit;

  assign bitLast   = 3'd4 + {1'b0, codeQ};
  assign tickEnd   = ovsTick && (tickCnt == TICK_LAST);
  assign dataReady = (state == ST_IDLE) && globalEn && txEn;
  assign accept    = dataReady && dataValid;
  assign lastBit   = (bitCnt == bitLast);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe       = '0;
    strobe.load  = accept;
    strobe.shift = tickEnd && ((state == ST_START) || ((state == ST_DATA) && !lastBit));
    strobe.stop  = tickEnd && (state == ST_DATA) && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      codeQ   <= 2'b11;
    end else if (state == ST_IDLE) begin
      tickCnt <= '0;
      if (accept) begin
        state <= ST_START;
        codeQ <= wordLenCode;
      end
    end else if (ovsTick) begin
      if (tickEnd) begin
        tickCnt <= '0;
        unique case (state)
          ST_START: begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (lastBit) state <= ST_STOP;
            else bitCnt <= bitCnt + 3'd1;
          end
          default: state <= ST_IDLE;
        endcase
      end else begin
        tickCnt <= tickCnt + TW'(1);
      end
    end
  end

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |=> busy);

  p_gated_by_enables_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(globalEn && txEn) |-> !dataReady);

  p_frame_continues_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ovsTick) |=> busy);

endmodule

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  utxStrobe_t          strobe,
  input  logic [DATA_MAX-1:0] dataIn,
  output logic                serialOut
);

  logic [DATA_MAX-1:0] shiftQ;
  logic                lineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      lineQ  <= 1'b1;
    end else if (strobe.load) begin
      shiftQ <= dataIn;
      lineQ  <= 1'b0;
    end else if (strobe.shift) begin
      lineQ  <= shiftQ[0];
      shiftQ <= shiftQ >> 1;
    end else if (strobe.stop) begin
      lineQ  <= 1'b1;
    end
  end

  assign serialOut = lineQ;

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !serialOut);

  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stop |=> serialOut);

endmodule

// File: rtl/uart_tx_graceful.sv
module uart_tx_graceful
  import utx_pkg::*;
#(
  parameter int OVS_RATIO = 16,
  parameter int DATA_MAX  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ovsTick,
  input  logic                globalEn,
  input  logic                txEn,
  input  logic [1:0]          wordLenCode,
  input  logic [DATA_MAX-1:0] dataIn,
  input  logic                dataValid,
  output logic                dataReady,
  output logic                serialOut,
  output logic                busy
);

  utxStrobe_t strobe;

  utx_ctrl #(.OVS_RATIO(OVS_RATIO)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ovsTick    (ovsTick),
    .globalEn   (globalEn),
    .txEn       (txEn),
    .wordLenCode(wordLenCode),
    .dataValid  (dataValid),
    .dataReady  (dataReady),
    .busy       (busy),
    .strobe     (strobe)
  );

  utx_datapath #(.DATA_MAX(DATA_MAX)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .serialOut(serialOut)
  );

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serialOut);

  p_ticks_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ovsTick) |=> $stable(serialOut));

  p_ends_on_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> serialOut);

endmodule

// File: tb/sim_uart_tx_graceful.sv
`timescale 1ns/1ps
module sim_uart_tx_graceful;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ovsTick;
  logic       globalEn = 1'b0;
  logic       txEn = 1'b0;
  logic [1:0] wordLenCode = 2'b11;
  logic [7:0] dataIn = '0;
  logic       dataValid = 1'b0;
  logic       dataReady;
  logic       serialOut;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  int tickDiv = 1;
  int divCnt  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  assign ovsTick = (divCnt == 0);
  always @(posedge clk) divCnt <= (divCnt >= tickDiv - 1) ? 0 : divCnt + 1;

  uart_tx_graceful u0 (
    .clk(clk), .rstN(rstN), .ovsTick(ovsTick), .globalEn(globalEn), .txEn(txEn),
    .wordLenCode(wordLenCode), .dataIn(dataIn), .dataValid(dataValid),
    .dataReady(dataReady), .serialOut(serialOut), .busy(busy)
  );

  // {code, data, expected line bits: bit k is k-th bit on the line, start first}
  localparam int NVEC = 8;
  localparam logic [19:0] VECS [NVEC] = '{
    {2'b11, 8'hA5, 10'b1101001010},
    {2'b11, 8'h3C, 10'b1001111000},
    {2'b00, 8'hE6, 10'b0001001100},
    {2'b01, 8'hC9, 10'b0010010010},
    {2'b10, 8'h80, 10'b0100000000},
    {2'b10, 8'h55, 10'b0110101010},
    {2'b00, 8'h1F, 10'b0001111110},
    {2'b11, 8'h00, 10'b1000000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // dropSel: 0 none, 1 clear txEn mid-frame, 2 clear globalEn mid-frame
  task automatic runFrame(input logic [1:0] code, input logic [7:0] data,
                          input logic [9:0] expBits, input int dropSel);
    int nBits;
    nBits = 5 + int'(code);
    @(negedge clk);
    wordLenCode = code;
    dataIn = data;
    dataValid = 1'b1;
    while (!dataReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    dataValid = 1'b0;
    wordLenCode = ~code;  // captured value must hold for the whole frame (R3)
    dataIn = ~data;
    chk("R5 start bit after accept", serialOut, 1'b0);
    chk("R8 busy at start", busy, 1'b1);
    repeat (8 * tickDiv) @(negedge clk);
    chk("R2 start bit mid", serialOut, expBits[0]);
    if (dropSel == 1) txEn = 1'b0;
    if (dropSel == 2) globalEn = 1'b0;
    for (int k = 1; k <= nBits + 1; k++) begin
      repeat (16 * tickDiv) @(negedge clk);
      if (k <= nBits) chk("R3 data bit", serialOut, expBits[k]);
      else chk("R4 stop bit follows last selected bit", serialOut, 1'b1);
      chk(dropSel != 0 ? "R7 busy holds after disable" : "R8 busy during frame", busy, 1'b1);
    end
    repeat (9 * tickDiv) @(negedge clk);
    chk("R8 busy clear after stop", busy, 1'b0);
    chk("R1 line idle high", serialOut, 1'b1);
    if (dropSel != 0) chk("R7 no accept after disable", dataReady, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset line", serialOut, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 not ready when disabled", dataReady, 1'b0);
    globalEn = 1'b1;
    txEn = 1'b1;
    @(negedge clk);
    chk("R5 ready when idle and enabled", dataReady, 1'b1);

    // table walk, tick every clock
    for (int v = 0; v < NVEC; v++)
      runFrame(VECS[v][19:18], VECS[v][17:10], VECS[v][9:0], 0);

    // R6: each enable alone blocks acceptance
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      globalEn = (m == 1);
      txEn = (m == 0);
      dataIn = 8'h00;
      dataValid = 1'b1;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (c % 10 == 0) begin
          chk("R6 ready low while disabled", dataReady, 1'b0);
          chk("R6 line high while disabled", serialOut, 1'b1);
          chk("R6 busy low while disabled", busy, 1'b0);
        end
      end
      dataValid = 1'b0;
    end
    globalEn = 1'b1;
    txEn = 1'b1;

    // R7: disable mid-frame via each enable
    runFrame(2'b11, 8'h96, 10'b1100101100, 1);
    @(negedge clk); txEn = 1'b1;
    runFrame(2'b01, 8'h2D, 10'b0011011010, 2);
    @(negedge clk); globalEn = 1'b1;

    // R9: slower tick stretches every bit
    tickDiv = 3;
    runFrame(2'b11, 8'hB1, 10'b1101100010, 0);
    runFrame(2'b00, 8'h0A, 10'b0001010100, 0);
    tickDiv = 1;

    // R9: without ticks the start bit never ends
    tickDiv = 1000;
    @(negedge clk);
    dataIn = 8'hFF;
    wordLenCode = 2'b11;
    dataValid = 1'b1;
    while (!dataReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    dataValid = 1'b0;
    repeat (200) @(negedge clk);
    chk("R9 bit held without enough ticks", serialOut, 1'b0);
    chk("R9 busy held without enough ticks", busy, 1'b1);
    tickDiv = 1;
    repeat (16 * 12) @(negedge clk);
    chk("R8 frame finishes once ticks resume", busy, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule